// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs single operations on a raw NAND flash device under software control. Software fills a small register file with two command bytes, a 16-bit cycle code, a column address, a row address with a chip-select field, and a data byte count. It then sets the start bit. The engine walks a fixed list of bus phases and runs only those whose code bit is set. The phases cover the first command, five single address bytes, data out of an on-chip page buffer, the second command, a wait for ready, data into the page buffer, a status byte capture and a five-byte identifier capture.

When the walk ends the engine raises an idle flag, which can drive an interrupt line. Software clears the flag by writing a 1. A ready wait that lasts longer than a programmable number of cycles ends the operation early and sets an error flag. While an operation runs, the command, address, size, configuration and timeout registers are frozen, so a second start cannot disturb it.

The bus has one address bit that selects between the register file and the page buffer. When the top address bit is 0, `bus_addr[3:0]` picks a 32-bit register. When it is 1, the low bits pick a byte of the page buffer.

Top module: `nseq_top`

## Requirements
- R1: After reset all of the following hold. Every chip enable and both strobes are high, and CLE and ALE are low. The flag register (index 8) reads 0. The start bit, bit 0 of the command register (index 1), reads 0.
- R2: The cycle code sits in bits 23:8 of register index 1. Its bits run the phases in this fixed order, each only when its bit is set:
  - bit 14: first command
  - bit 13: column byte 0
  - bit 12: column byte 1
  - bit 11: row byte 0
  - bit 10: row byte 1
  - bit 9: row byte 2
  - bit 8: data out
  - bit 7: second command
  - bit 6: wait ready
  - bit 5: data in
  - bit 3: status read
  - bit 2: identifier read

  Code bits 15, 4, 1 and 0 have no effect.
- R3: A command cycle drives CLE high, ALE low and one byte on DQ. The first command byte comes from bits 31:24 of index 1. The second comes from bits 31:24 of index 0.
- R4: An address cycle drives ALE high. Column bytes come from index 2 bits 15:0 and row bytes from index 3 bits 23:0, each low byte first. When config bit 7 (index 5) is set, the column sent is the stored column shifted right by one.
- R5: Data out sends page-buffer bytes 0 up to N-1 with CLE and ALE low, where N is the byte count in index 4. When N is 0 the phase is skipped.
- R6: Data in reads N bytes with RE# strobes into page-buffer bytes 0 up to N-1, which software then reads through the buffer window.
- R7: Identifier read captures five bytes. Bytes 0 to 3 go into index 6, with byte 0 in bits 31:24 and byte 3 in bits 7:0. Byte 4 goes into bits 31:24 of index 7. Status read puts its byte in bits 7:0 of index 7.
- R8: The wait phase holds until the ready input is high. If the input stays low for longer than the cycle count in index 9, the operation ends at once. Flag bits 29 and 28 are then set, and bit 30 is not.
- R9: A normal end sets flag bits 29 (idle) and 30 (done). The interrupt output equals bit 29 AND the enable in bit 20. Writing 1 to bit 17 clears bit 29, and writing 1 to bit 18 clears bits 30 and 28.
- R10: The start bit reads 1 from start until the operation ends. While it is 1, writes to indexes 0 to 5 and 9 are ignored, including a new start.
- R11: During an operation, chip enable i is low exactly when bit 24+i of index 3 is set. When no operation runs, all chip enables are high.
- R12: Each WE# or RE# strobe stays low for STB_CYC clock cycles and then high for STB_CYC cycles. CLE, ALE and DQ hold their values across the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register or buffer access |
| bus_addr | input | $clog2(BUF_DEPTH)+1 | Top bit selects the buffer; low bits give the register index or the buffer byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register or buffer byte |
| irq | output | 1 | Idle flag AND interrupt enable |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Data returned from the device |
| nand_rb | input | 1 | Ready (high) / busy (low) from the device |

## Verification
The bench targets these corner cases, and each one shows a specific fault:
- **Code bits with no phase.** It sets bits 15, 4, 1 and 0 alongside a first command. A decoder that mapped them to a phase would put extra strobes on the bus.
- **Zero byte count.** It runs a status read with a count of 0. An engine that did not skip the data-in phase would use up extra device bytes and wreck the status capture.
- **Writes while busy.** It restarts with a different code and column while the ready wait is stalled. A register file that was not frozen would show changed read-back or send a second, unexpected command.
- **Timeout.** It lets the ready input time out. The result must set error and idle but not done.
- **Halved column.** It runs the column in 16-bit mode. A missing shift shows up as the wrong address byte.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

   // register indexes on the control bus
   localparam logic [3:0] REG_CMD_A = 4'd0;
   localparam logic [3:0] REG_CMD_B = 4'd1;
   localparam logic [3:0] REG_COL   = 4'd2;
   localparam logic [3:0] REG_ROW   = 4'd3;
   localparam logic [3:0] REG_XFER  = 4'd4;
   localparam logic [3:0] REG_CFG   = 4'd5;
   localparam logic [3:0] REG_CAP1  = 4'd6;
   localparam logic [3:0] REG_CAP2  = 4'd7;
   localparam logic [3:0] REG_FLAGS = 4'd8;
   localparam logic [3:0] REG_TMO   = 4'd9;

   // phase steps; step s is enabled by code bit (14 - s)
   localparam logic [3:0] STP_CMD1 = 4'd0;
   localparam logic [3:0] STP_COL0 = 4'd1;
   localparam logic [3:0] STP_COL1 = 4'd2;
   localparam logic [3:0] STP_ROW0 = 4'd3;
   localparam logic [3:0] STP_ROW1 = 4'd4;
   localparam logic [3:0] STP_ROW2 = 4'd5;
   localparam logic [3:0] STP_DOUT = 4'd6;
   localparam logic [3:0] STP_CMD2 = 4'd7;
   localparam logic [3:0] STP_WAIT = 4'd8;
   localparam logic [3:0] STP_DIN  = 4'd9;
   localparam logic [3:0] STP_GAP  = 4'd10;
   localparam logic [3:0] STP_STAT = 4'd11;
   localparam logic [3:0] STP_ID   = 4'd12;
   localparam logic [3:0] STP_END  = 4'd13;

   localparam int ID_BYTES = 5;

   typedef enum logic [1:0] {BC_IDLE, BC_LOW, BC_HIGH} bc_state_t;
   typedef enum logic [1:0] {SQ_IDLE, SQ_SCAN, SQ_BUS, SQ_WAIT} sq_state_t;

endpackage

// File: rtl/nseq_bus_cycle.sv
module nseq_bus_cycle
   import nseq_pkg::*;
#(
   parameter int STB_CYC = 2,
   parameter int DQ_W    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            rd,
   input  logic            cle_in,
   input  logic            ale_in,
   input  logic [DQ_W-1:0] wdata,
   output logic            done,
   output logic [DQ_W-1:0] rdata,
   output logic            we_n,
   output logic            re_n,
   output logic            cle,
   output logic            ale,
   output logic [DQ_W-1:0] dq_o,
   output logic            dq_oe,
   input  logic [DQ_W-1:0] dq_i
);
   localparam int CW = $clog2(STB_CYC + 1);
   localparam logic [CW-1:0] TC_LAST = CW'(STB_CYC - 1);

   generate
      if (STB_CYC < 1) begin : g_bad_stb
         $error("STB_CYC must be at least 1");
      end
   endgenerate

   bc_state_t       st;
   logic [CW-1:0]   tc;
   logic            l_rd, l_cle, l_ale;
   logic [DQ_W-1:0] l_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= BC_IDLE;
         tc    <= '0;
         l_rd  <= 1'b0;
         l_cle <= 1'b0;
         l_ale <= 1'b0;
         l_dat <= '0;
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            BC_IDLE: if (go) begin
               st    <= BC_LOW;
               tc    <= '0;
               l_rd  <= rd;
               l_cle <= cle_in;
               l_ale <= ale_in;
               l_dat <= wdata;
            end
            BC_LOW: if (tc == TC_LAST) begin
               st <= BC_HIGH;
               tc <= '0;
               if (l_rd) rdata <= dq_i;
            end else begin
               tc <= tc + 1'b1;
            end
            BC_HIGH: if (tc == TC_LAST) begin
               st   <= BC_IDLE;
               tc   <= '0;
               done <= 1'b1;
            end else begin
               tc <= tc + 1'b1;
            end
            default: st <= BC_IDLE;
         endcase
      end
   end

   logic active;
   assign active = (st != BC_IDLE);
   assign we_n   = !(st == BC_LOW && !l_rd);
   assign re_n   = !(st == BC_LOW && l_rd);
   assign cle    = active && l_cle;
   assign ale    = active && l_ale;
   assign dq_o   = l_dat;
   assign dq_oe  = active && !l_rd;

   AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R3
   AST_WE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> ($stable(dq_o) && $stable(cle) && $stable(ale))); // R12
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (we_n || re_n)); // R12

endmodule

// File: rtl/nseq_pagebuf.sv
module nseq_pagebuf #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          sw_we,
   input  logic [AW-1:0] sw_addr,
   input  logic [7:0]    sw_wdata,
   output logic [7:0]    sw_rdata,
   input  logic          eng_we,
   input  logic [AW-1:0] eng_addr,
   input  logic [7:0]    eng_wdata,
   output logic [7:0]    eng_rdata
);
   logic [7:0] mem [DEPTH];

   // engine port has priority; software writes are gated off while busy
   always_ff @(posedge clk) begin
      if (eng_we)     mem[eng_addr] <= eng_wdata;
      else if (sw_we) mem[sw_addr]  <= sw_wdata;
   end

   assign sw_rdata  = mem[sw_addr];
   assign eng_rdata = mem[eng_addr];
endmodule

// File: rtl/nseq_regs.sv
module nseq_regs
   import nseq_pkg::*;
#(
   parameter int XFER_W = 16,
   parameter int TMO_W  = 20,
   parameter logic [TMO_W-1:0] TMO_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        idx,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              busy,
   input  logic              fin,
   input  logic              fin_err,
   input  logic [31:0]       cap1,
   input  logic [31:0]       cap2,
   output logic              start,
   output logic [7:0]        byte1,
   output logic [7:0]        byte2,
   output logic [15:0]       code,
   output logic [15:0]       col,
   output logic [23:0]       row,
   output logic [3:0]        cs,
   output logic              wide,
   output logic [XFER_W-1:0] xfer,
   output logic [TMO_W-1:0]  tmo,
   output logic              irq
);
   logic [3:0] rbsel;
   logic [1:0] bufno;
   logic       irq_en, idle_f, done_f, err_f;
   logic       cfg_wr;

   assign cfg_wr = wr_en && !busy;
   assign start  = cfg_wr && (idx == REG_CMD_B) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte1 <= '0; byte2 <= '0; code <= '0; bufno <= '0;
         col <= '0; row <= '0; cs <= '0; rbsel <= '0;
         xfer <= '0; wide <= 1'b0; tmo <= TMO_RESET;
         irq_en <= 1'b0; idle_f <= 1'b0; done_f <= 1'b0; err_f <= 1'b0;
      end else begin
         if (cfg_wr) begin
            case (idx)
               REG_CMD_A: byte2 <= wdata[31:24];
               REG_CMD_B: begin
                  byte1 <= wdata[31:24];
                  code  <= wdata[23:8];
                  bufno <= wdata[2:1];
               end
               REG_COL:  col <= wdata[15:0];
               REG_ROW: begin
                  row   <= wdata[23:0];
                  cs    <= wdata[27:24];
                  rbsel <= wdata[31:28];
               end
               REG_XFER: xfer <= wdata[XFER_W-1:0];
               REG_CFG:  wide <= wdata[7];
               REG_TMO:  tmo  <= wdata[TMO_W-1:0];
               default: ;
            endcase
         end
         if (wr_en && idx == REG_FLAGS) begin
            irq_en <= wdata[20];
            if (wdata[17]) idle_f <= 1'b0;
            if (wdata[18]) begin
               done_f <= 1'b0;
               err_f  <= 1'b0;
            end
         end
         if (fin) begin
            idle_f <= 1'b1;
            if (fin_err) err_f  <= 1'b1;
            else         done_f <= 1'b1;
         end
      end
   end

   always_comb begin
      case (idx)
         REG_CMD_A: rdata = {byte2, 24'h0};
         REG_CMD_B: rdata = {byte1, code, 5'h0, bufno, busy};
         REG_COL:   rdata = {16'h0, col};
         REG_ROW:   rdata = {rbsel, cs, row};
         REG_XFER:  rdata = 32'(xfer);
         REG_CFG:   rdata = {24'h0, wide, 7'h0};
         REG_CAP1:  rdata = cap1;
         REG_CAP2:  rdata = cap2;
         REG_FLAGS: rdata = {1'b0, done_f, idle_f, err_f, 7'h0, irq_en, 20'h0};
         REG_TMO:   rdata = 32'(tmo);
         default:   rdata = 32'h0;
      endcase
   end

   assign irq = idle_f && irq_en;

   AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(code) && $stable(byte1) && $stable(col) && $stable(row))); // R10
   AST_IDLE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idle_f) |-> $past(busy)); // R9
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_f) |-> !$rose(err_f))); // R8

endmodule

// File: rtl/nseq_seq.sv
module nseq_seq
   import nseq_pkg::*;
#(
   parameter int XFER_W = 16,
   parameter int TMO_W  = 20,
   parameter int BUF_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        byte1,
   input  logic [7:0]        byte2,
   input  logic [15:0]       code,
   input  logic [15:0]       col,
   input  logic [23:0]       row,
   input  logic              wide,
   input  logic [XFER_W-1:0] xfer,
   input  logic [TMO_W-1:0]  tmo,
   input  logic              rb,
   output logic              busy,
   output logic              fin,
   output logic              fin_err,
   output logic              bc_go,
   output logic              bc_rd,
   output logic              bc_cle,
   output logic              bc_ale,
   output logic [7:0]        bc_wdata,
   input  logic              bc_done,
   input  logic [7:0]        bc_rdata,
   output logic              buf_we,
   output logic [BUF_AW-1:0] buf_addr,
   output logic [7:0]        buf_wdata,
   input  logic [7:0]        buf_rdata,
   output logic [31:0]       cap1,
   output logic [31:0]       cap2
);
   sq_state_t         st;
   logic [3:0]        step;
   logic [XFER_W-1:0] cnt;
   logic [TMO_W-1:0]  tmr;

   logic [15:0]       col_eff;
   logic              bit_on;
   logic [XFER_W-1:0] nbytes;
   logic              is_last;

   assign col_eff = wide ? {1'b0, col[15:1]} : col;
   assign bit_on  = (step < STP_END) && (step != STP_GAP) && code[4'd14 - step];
   assign busy    = (st != SQ_IDLE);

   always_comb begin
      if (step == STP_DOUT || step == STP_DIN) nbytes = xfer;
      else if (step == STP_ID)                 nbytes = XFER_W'(ID_BYTES);
      else                                     nbytes = XFER_W'(1);
   end
   assign is_last = (cnt == nbytes - XFER_W'(1));

   // per-step cycle parameters
   always_comb begin
      bc_rd    = 1'b0;
      bc_cle   = 1'b0;
      bc_ale   = 1'b0;
      bc_wdata = 8'h00;
      case (step)
         STP_CMD1: begin bc_cle = 1'b1; bc_wdata = byte1; end
         STP_COL0: begin bc_ale = 1'b1; bc_wdata = col_eff[7:0]; end
         STP_COL1: begin bc_ale = 1'b1; bc_wdata = col_eff[15:8]; end
         STP_ROW0: begin bc_ale = 1'b1; bc_wdata = row[7:0]; end
         STP_ROW1: begin bc_ale = 1'b1; bc_wdata = row[15:8]; end
         STP_ROW2: begin bc_ale = 1'b1; bc_wdata = row[23:16]; end
         STP_DOUT: bc_wdata = buf_rdata;
         STP_CMD2: begin bc_cle = 1'b1; bc_wdata = byte2; end
         STP_DIN, STP_STAT, STP_ID: bc_rd = 1'b1;
         default: ;
      endcase
   end

   assign bc_go = (st == SQ_SCAN) && bit_on && (step != STP_WAIT) && (nbytes != '0);
   assign buf_addr  = cnt[BUF_AW-1:0];
   assign buf_we    = (st == SQ_BUS) && bc_done && (step == STP_DIN);
   assign buf_wdata = bc_rdata;

   logic tmo_hit;
   assign tmo_hit = (st == SQ_WAIT) && !rb && (tmr >= tmo);
   assign fin     = ((st == SQ_SCAN) && (step == STP_END)) || tmo_hit;
   assign fin_err = tmo_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SQ_IDLE;
         step <= '0;
         cnt  <= '0;
         tmr  <= '0;
         cap1 <= '0;
         cap2 <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (start) begin
               st   <= SQ_SCAN;
               step <= STP_CMD1;
               cnt  <= '0;
            end
            SQ_SCAN: begin
               if (step == STP_END) begin
                  st <= SQ_IDLE;
               end else if (!bit_on || (step != STP_WAIT && nbytes == '0)) begin
                  step <= step + 4'd1;
               end else if (step == STP_WAIT) begin
                  st  <= SQ_WAIT;
                  tmr <= '0;
               end else begin
                  st <= SQ_BUS;
               end
            end
            SQ_BUS: if (bc_done) begin
               if (step == STP_ID) begin
                  case (cnt[2:0])
                     3'd0: cap1[31:24] <= bc_rdata;
                     3'd1: cap1[23:16] <= bc_rdata;
                     3'd2: cap1[15:8]  <= bc_rdata;
                     3'd3: cap1[7:0]   <= bc_rdata;
                     default: cap2[31:24] <= bc_rdata;
                  endcase
               end else if (step == STP_STAT) begin
                  cap2[7:0] <= bc_rdata;
               end
               st <= SQ_SCAN;
               if (is_last) begin
                  cnt  <= '0;
                  step <= step + 4'd1;
               end else begin
                  cnt <= cnt + XFER_W'(1);
               end
            end
            SQ_WAIT: begin
               if (rb) begin
                  st   <= SQ_SCAN;
                  step <= step + 4'd1;
               end else if (tmr >= tmo) begin
                  st <= SQ_IDLE;
               end else begin
                  tmr <= tmr + TMO_W'(1);
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_WAIT) |-> (tmr <= tmo)); // R8
   AST_WAIT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fin_err |-> !rb); // R8
   AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (step >= $past(step))); // R2

endmodule

// File: rtl/nseq_top.sv
module nseq_top
   import nseq_pkg::*;
#(
   parameter int BUF_DEPTH = 256,
   parameter int NUM_CS    = 2,
   parameter int STB_CYC   = 2,
   parameter int XFER_W    = 16,
   parameter int TMO_W     = 20,
   parameter logic [TMO_W-1:0] TMO_RESET = TMO_W'(100000)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic [$clog2(BUF_DEPTH):0]   bus_addr,
   input  logic [31:0]                  bus_wdata,
   output logic [31:0]                  bus_rdata,
   output logic                         irq,
   output logic [NUM_CS-1:0]            nand_ce_n,
   output logic                         nand_cle,
   output logic                         nand_ale,
   output logic                         nand_we_n,
   output logic                         nand_re_n,
   output logic [7:0]                   nand_dq_o,
   output logic                         nand_dq_oe,
   input  logic [7:0]                   nand_dq_i,
   input  logic                         nand_rb
);
   localparam int BUF_AW = $clog2(BUF_DEPTH);

   generate
      if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
         $error("NUM_CS must be 1 to 4");
      end
      if (BUF_AW < 4) begin : g_bad_depth
         $error("BUF_DEPTH must be at least 16");
      end
      if (XFER_W < 4 || XFER_W > 32 || TMO_W < 2 || TMO_W > 32) begin : g_bad_w
         $error("XFER_W and TMO_W out of range");
      end
   endgenerate

   logic              is_buf;
   logic              busy, fin, fin_err, start;
   logic [31:0]       reg_rdata, cap1, cap2;
   logic [7:0]        byte1, byte2;
   logic [15:0]       code, col;
   logic [23:0]       row;
   logic [3:0]        cs;
   logic              wide;
   logic [XFER_W-1:0] xfer;
   logic [TMO_W-1:0]  tmo;
   logic              bc_go, bc_rd, bc_cle, bc_ale, bc_done;
   logic [7:0]        bc_wdata, bc_rdata;
   logic              buf_we;
   logic [BUF_AW-1:0] buf_addr;
   logic [7:0]        buf_wdata, buf_rdata, sw_rdata;

   assign is_buf = bus_addr[BUF_AW];

   nseq_regs #(.XFER_W(XFER_W), .TMO_W(TMO_W), .TMO_RESET(TMO_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && !is_buf), .idx(bus_addr[3:0]),
      .wdata(bus_wdata), .rdata(reg_rdata), .busy(busy), .fin(fin), .fin_err(fin_err),
      .cap1(cap1), .cap2(cap2), .start(start), .byte1(byte1), .byte2(byte2),
      .code(code), .col(col), .row(row), .cs(cs), .wide(wide), .xfer(xfer),
      .tmo(tmo), .irq(irq));

   nseq_seq #(.XFER_W(XFER_W), .TMO_W(TMO_W), .BUF_AW(BUF_AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .byte1(byte1), .byte2(byte2),
      .code(code), .col(col), .row(row), .wide(wide), .xfer(xfer), .tmo(tmo),
      .rb(nand_rb), .busy(busy), .fin(fin), .fin_err(fin_err),
      .bc_go(bc_go), .bc_rd(bc_rd), .bc_cle(bc_cle), .bc_ale(bc_ale),
      .bc_wdata(bc_wdata), .bc_done(bc_done), .bc_rdata(bc_rdata),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .buf_rdata(buf_rdata), .cap1(cap1), .cap2(cap2));

   nseq_bus_cycle #(.STB_CYC(STB_CYC), .DQ_W(8)) u_cyc (
      .clk(clk), .rst_n(rst_n), .go(bc_go), .rd(bc_rd), .cle_in(bc_cle),
      .ale_in(bc_ale), .wdata(bc_wdata), .done(bc_done), .rdata(bc_rdata),
      .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
      .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .dq_i(nand_dq_i));

   nseq_pagebuf #(.DEPTH(BUF_DEPTH), .AW(BUF_AW)) u_buf (
      .clk(clk), .sw_we(bus_wr && is_buf && !busy), .sw_addr(bus_addr[BUF_AW-1:0]),
      .sw_wdata(bus_wdata[7:0]), .sw_rdata(sw_rdata),
      .eng_we(buf_we), .eng_addr(buf_addr), .eng_wdata(buf_wdata),
      .eng_rdata(buf_rdata));

   assign bus_rdata = is_buf ? {24'h0, sw_rdata} : reg_rdata;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CS; gi++) begin : g_ce
         assign nand_ce_n[gi] = !(busy && cs[gi]);
      end
   endgenerate

   logic unused_cs;
   assign unused_cs = ^cs;

   AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (&nand_ce_n)); // R11
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale)); // R1

endmodule

// File: tb/nseq_top_test.sv
`timescale 1ns/1ps
module nseq_top_test;
   localparam int STB = 2;
   localparam int BD  = 256;
   localparam int AW  = $clog2(BD) + 1;
   localparam logic [AW-1:0] BUFW = AW'(BD);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq;
   logic [1:0] nand_ce_n;
   logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0] nand_dq_o;
   logic [7:0] nand_dq_i = 8'h00;
   logic nand_rb = 1'b1;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   nseq_top #(.BUF_DEPTH(BD), .NUM_CS(2), .STB_CYC(STB)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
      .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, got, exp);
      end
   endtask

   // scoreboard: expected write cycles {kind, byte}; kind 1 cmd, 2 addr, 3 data
   logic [9:0] exp_q[$];
   logic [7:0] dev_q[$];

   task automatic ex(input logic [1:0] k, input logic [7:0] b);
      exp_q.push_back({k, b});
   endtask

   logic we_prev = 1'b1;
   logic re_prev = 1'b1;
   int   low_cnt = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!nand_we_n) low_cnt++;
         if (nand_we_n && !we_prev) begin
            logic [9:0] got;
            got = {(nand_cle ? 2'd1 : nand_ale ? 2'd2 : 2'd3), nand_dq_o};
            chk("R12 strobe low width", 32'(low_cnt), 32'(STB));
            low_cnt = 0;
            if (exp_q.size() == 0) begin
               chk("R2 unexpected bus cycle", 32'(got), 32'h3ff);
            end else begin
               logic [9:0] e;
               e = exp_q.pop_front();
               chk(e[9:8] == 2'd1 ? "R3 command cycle" :
                   e[9:8] == 2'd2 ? "R4 address cycle" : "R5 data-out cycle",
                   32'(got), 32'(e));
            end
         end
         if (!nand_re_n && re_prev) begin
            if (dev_q.size() != 0) nand_dq_i <= dev_q.pop_front();
            else                   nand_dq_i <= 8'hEE;
         end
         we_prev <= nand_we_n;
         re_prev <= nand_re_n;
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         rd(AW'(8), v);
         if (v[29]) break;
      end
   endtask

   task automatic clear_flags();
      wr(AW'(8), 32'h0016_0000);
   endtask

   task automatic queue_done(input string req);
      chk(req, 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(AW'(8), v); chk("R1 flags after reset", v, 32'h0);
      rd(AW'(1), v); chk("R1 start bit after reset", {31'h0, v[0]}, 32'h0);
      chk("R1 pins after reset", {26'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale},
          {26'h0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0});

      // R2/R3/R9 reset operation, interrupt and clear
      wr(AW'(8), 32'h0010_0000);
      wr(AW'(3), 32'h1100_0000);
      ex(2'd1, 8'hFF);
      wr(AW'(1), 32'hFF40_4001);
      wait_idle();
      queue_done("R3 reset op cycles");
      rd(AW'(8), v); chk("R9 flags after normal end", v, 32'h6010_0000);
      chk("R9 irq raised", {31'h0, irq}, 32'h1);
      wr(AW'(8), 32'h0016_0000);
      rd(AW'(8), v); chk("R9 flags after w1c", v, 32'h0010_0000);
      chk("R9 irq dropped", {31'h0, irq}, 32'h0);

      // R4 block erase row bytes
      wr(AW'(3), 32'h1101_2345);
      wr(AW'(0), 32'hD000_0000);
      ex(2'd1, 8'h60); ex(2'd2, 8'h45); ex(2'd2, 8'h23); ex(2'd2, 8'h01); ex(2'd1, 8'hD0);
      wr(AW'(1), 32'h604E_C001);
      wait_idle(); clear_flags();
      queue_done("R4 erase cycles");

      // R5 page program with buffer data; R11 chip 0 enable
      wr(BUFW | AW'(0), 32'hA5); wr(BUFW | AW'(1), 32'h5A);
      wr(BUFW | AW'(2), 32'h3C); wr(BUFW | AW'(3), 32'hC3);
      wr(AW'(2), 32'h0004);
      wr(AW'(3), 32'h1100_0102);
      wr(AW'(4), 32'd4);
      wr(AW'(0), 32'h1000_0000);
      ex(2'd1, 8'h80); ex(2'd2, 8'h04); ex(2'd2, 8'h00);
      ex(2'd2, 8'h02); ex(2'd2, 8'h01); ex(2'd2, 8'h00);
      ex(2'd3, 8'hA5); ex(2'd3, 8'h5A); ex(2'd3, 8'h3C); ex(2'd3, 8'hC3);
      ex(2'd1, 8'h10);
      wr(AW'(1), 32'h807F_C001);
      @(negedge clk);
      chk("R11 chip 0 enable during op", {30'h0, nand_ce_n}, 32'h2);
      wait_idle(); clear_flags();
      queue_done("R5 program cycles");
      chk("R11 chip enables idle", {30'h0, nand_ce_n}, 32'h3);

      // R6 page read in 16-bit mode (R4 halved column), R8 wait holds, R11 chip 1
      nand_rb = 1'b0;
      wr(AW'(5), 32'h80);
      wr(AW'(2), 32'h0010);
      wr(AW'(3), 32'h1200_0203);
      wr(AW'(4), 32'd3);
      wr(AW'(0), 32'h3000_0000);
      dev_q.push_back(8'h11); dev_q.push_back(8'h22); dev_q.push_back(8'h33);
      ex(2'd1, 8'h00); ex(2'd2, 8'h08); ex(2'd2, 8'h00);
      ex(2'd2, 8'h03); ex(2'd2, 8'h02); ex(2'd2, 8'h00); ex(2'd1, 8'h30);
      wr(AW'(1), 32'h007E_E001);
      repeat (200) @(negedge clk);
      rd(AW'(1), v); chk("R8 still waiting while not ready", {31'h0, v[0]}, 32'h1);
      chk("R8 no reads before ready", 32'(dev_q.size()), 32'd3);
      chk("R11 chip 1 enable during op", {30'h0, nand_ce_n}, 32'h1);
      nand_rb = 1'b1;
      wait_idle(); clear_flags();
      queue_done("R4 read cycles with halved column");
      rd(BUFW | AW'(0), v); chk("R6 buffer byte 0", v, 32'h11);
      rd(BUFW | AW'(1), v); chk("R6 buffer byte 1", v, 32'h22);
      rd(BUFW | AW'(2), v); chk("R6 buffer byte 2", v, 32'h33);
      wr(AW'(5), 32'h0);

      // R7 identifier read
      wr(AW'(3), 32'h1100_0000);
      dev_q.push_back(8'h2C); dev_q.push_back(8'hDA); dev_q.push_back(8'h90);
      dev_q.push_back(8'h95); dev_q.push_back(8'h44);
      ex(2'd1, 8'h90); ex(2'd2, 8'h00);
      wr(AW'(1), 32'h9048_0401);
      wait_idle(); clear_flags();
      queue_done("R7 id cycles");
      rd(AW'(6), v); chk("R7 id bytes 0-3", v, 32'h2CDA_9095);
      rd(AW'(7), v); chk("R7 id byte 4", v & 32'hFF00_0000, 32'h4400_0000);

      // R7 status read with zero count: data-in skipped (R5/R6)
      wr(AW'(4), 32'd0);
      dev_q.push_back(8'hE0);
      ex(2'd1, 8'h70);
      wr(AW'(1), 32'h7040_6801);
      wait_idle(); clear_flags();
      queue_done("R7 status cycles");
      rd(AW'(7), v); chk("R7 status byte", v, 32'h4400_00E0);
      chk("R6 zero count skips data-in", 32'(dev_q.size()), 32'd0);

      // R2 code bits 15, 4, 1, 0 have no effect
      ex(2'd1, 8'hFF);
      wr(AW'(1), 32'hFFC0_5301);
      wait_idle(); clear_flags();
      repeat (40) @(negedge clk);
      queue_done("R2 ignored code bits");

      // R10 writes while busy are ignored
      nand_rb = 1'b0;
      wr(AW'(2), 32'h0010);
      ex(2'd1, 8'hFF);
      wr(AW'(1), 32'hFF40_4001);
      repeat (30) @(negedge clk);
      wr(AW'(1), 32'h604E_C001);
      wr(AW'(2), 32'h0055);
      rd(AW'(1), v); chk("R10 command reg frozen, start reads 1", v, 32'hFF40_4001);
      rd(AW'(2), v); chk("R10 column reg frozen", v, 32'h0010);
      nand_rb = 1'b1;
      wait_idle(); clear_flags();
      repeat (60) @(negedge clk);
      rd(AW'(1), v); chk("R10 start bit clears at end", v, 32'hFF40_4000);
      queue_done("R10 no second operation");

      // R8 timeout
      nand_rb = 1'b0;
      wr(AW'(9), 32'd30);
      ex(2'd1, 8'hFF);
      wr(AW'(1), 32'hFF40_4001);
      wait_idle();
      rd(AW'(8), v); chk("R8 timeout flags", v, 32'h3010_0000);
      rd(AW'(1), v); chk("R8 engine stopped", {31'h0, v[0]}, 32'h0);
      queue_done("R8 timeout cycles");
      nand_rb = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule